// File: doc/BRIEF.md
# Banked Interrupt Controller Register File

This block collects up to 32 active-low interrupt request pins, latches them as pending events and presents two processor interrupt outputs: a normal one and a fast one. Each line is configured through its own word register with a 5-bit priority, a sensitivity (edge or level) and a steering bit that picks which output the line feeds. A mask register holds lines back without losing their pending state, and software can raise a line through a software-set register.

When an output has been granted permission to fire (its agreement flag is set) and a pending, unmasked line is steered to it, the output rises. In that same cycle the flag clears and the number of the winning line is latched. Software reads the line number from a source register; for edge lines that read also acknowledges the event. Writing the control register lowers an output and re-arms it, and the block then picks the next winner on its own. A separate resolver module finds the winning line number: the lowest priority value wins, and a tie goes to the highest line number.

Register access is a simple synchronous port. A write takes effect at the clock edge where `wr_en` is high. A read captures its data into `rdata` at the edge where `rd_en` is high. Byte addresses are word-aligned, and an address with nonzero low bits counts as unmapped.

Top module: `intc_bank`

## Requirements
- R1: After reset the mask register (byte 0x04) reads 0xFFFFFFFF, the pending register (0x00) reads 0, every line register reads 0, both source registers read 0, and `irq_o` and `fiq_o` are low.
- R2: The line register for line n sits at byte 0x1C + 4*n. Bits [6:2] hold the priority, bit 1 the sensitivity (1 = level, 0 = edge) and bit 0 the steering (1 = fast output, 0 = normal output). A read returns exactly these seven bits, with all other bits 0.
- R3: An edge line sets its pending bit only at a high-to-low transition of its pin. Holding the pin low does not set the bit again after it has been cleared.
- R4: A level line has its pending bit set at every edge while its pin is low, and the bit clears at the edge where the pin returns high. A clear written to the pending register does not clear a level line whose pin is low.
- R5: A write to the pending register (0x00) replaces the pending bits with their AND with the written value, apart from the level-line exception in R4.
- R6: An output rises only while its agreement flag is set and some pending, unmasked line is steered to it. The flag then clears, and the latched line number does not change until the output has been re-armed.
- R7: The latched winner is the candidate line with the lowest priority value; among equal priorities the highest line number wins.
- R8: A read of byte 0x10 (normal) or 0x14 (fast) returns the latched line number. If that line is edge-sensitive, the read also clears its pending bit; a level line stays pending.
- R9: A control write (0x18) with bit 0 set lowers `irq_o` at that edge and re-arms it; bit 1 does the same for `fiq_o`. If a candidate remains, the output rises again one edge later.
- R10: Masked lines (mask bit 1) never cause an output to fire, but they stay pending. A mask write that unmasks a pending line fires the output one edge later.
- R11: A write to byte 0x9C raises only the lowest-numbered set bit of the written value, in the same way an assertion of that pin would. An edge line whose pin is already low is not raised.
- R12: Reads of 0x18, 0x9C, unmapped or unaligned addresses return 0. Writes to the source registers or to unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| line_n | input | 32 | Interrupt request pins, active low, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address of the register word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid after the edge that sampled rd_en |
| irq_o | output | 1 | Normal interrupt output |
| fiq_o | output | 1 | Fast interrupt output |

## Verification
A pin change that is present before an edge shows up in the pending register at that edge, and the output it causes appears one edge later. Register writes take effect at the edge that samples the strobe, and read data is registered at the edge that samples `rd_en`. Any output effect of a write (unmask or re-arm) is therefore due one edge after the write. The bench drives and samples only on falling edges, and after each write it waits exactly one more falling edge before it checks an output. The winner order is checked by draining full and sparse pending sets one acknowledge at a time against an arithmetic model of priority and tie-break.

// File: rtl/intc_pkg.sv
package intc_pkg;
    // Word indices (byte address / 4) of the register windows
    localparam int unsigned WI_PEND    = 0;
    localparam int unsigned WI_MASK    = 1;
    localparam int unsigned WI_SRC_NRM = 4;
    localparam int unsigned WI_SRC_FST = 5;
    localparam int unsigned WI_CTRL    = 6;
    localparam int unsigned WI_CFG0    = 7;

    // Output path selectors, used as indices into the per-path arrays
    typedef enum logic [0:0] {
        PATH_NRM = 1'b0,
        PATH_FST = 1'b1
    } path_e;
endpackage

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
    parameter int NLINES = 32,
    parameter int PRIO_W = 5,
    parameter int LINE_W = $clog2(NLINES)
) (
    input  logic [NLINES-1:0]             cand,
    input  logic [NLINES-1:0][PRIO_W-1:0] prio,
    output logic [LINE_W-1:0]             win,
    output logic                          any
);
    logic [PRIO_W-1:0] best;

    // Ascending scan with <= : lowest value wins, ties go to the higher line
    always_comb begin
        best = '1;
        win  = '0;
        for (int i = 0; i < NLINES; i++) begin
            if (cand[i] && (prio[i] <= best)) begin
                best = prio[i];
                win  = LINE_W'(i);
            end
        end
    end

    assign any = |cand;
endmodule

// File: rtl/intc_line_events.sv
module intc_line_events #(
    parameter int NLINES = 32
) (
    input  logic [NLINES-1:0] asrt,     // pin active now
    input  logic [NLINES-1:0] in_prev,  // pin active at previous edge
    input  logic [NLINES-1:0] sens,     // 1 = level
    input  logic [NLINES-1:0] sw_req,   // one-hot software raise
    output logic [NLINES-1:0] set_vec,
    output logic [NLINES-1:0] fall_vec
);
    for (genvar i = 0; i < NLINES; i++) begin : g_line
        logic hw_set;
        logic sw_set;
        assign hw_set      = sens[i] ? asrt[i] : (asrt[i] & ~in_prev[i]);
        assign sw_set      = sw_req[i] & (sens[i] | ~asrt[i]);
        assign set_vec[i]  = hw_set | sw_set;
        assign fall_vec[i] = sens[i] & ~asrt[i] & in_prev[i];
    end
endmodule

// File: rtl/intc_bank.sv
module intc_bank
    import intc_pkg::*;
#(
    parameter int NLINES = 32,
    parameter int PRIO_W = 5,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NLINES-1:0] line_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_o,
    output logic              fiq_o
);
    localparam int LINE_W   = $clog2(NLINES);
    localparam int WIDX_W   = ADDR_W - 2;
    localparam int CFG_W    = PRIO_W + 2;
    localparam int WI_SWSET = WI_CFG0 + NLINES;

    typedef struct packed {
        logic [NLINES-1:0]             pend;
        logic [NLINES-1:0]             mask;
        logic [NLINES-1:0]             sens;
        logic [NLINES-1:0]             steer;
        logic [NLINES-1:0]             in_prev;
        logic [NLINES-1:0][PRIO_W-1:0] prio;
        logic [1:0]                    agree;
        logic [1:0]                    out;
        logic [1:0][LINE_W-1:0]        src;
        logic [DATA_W-1:0]             rdata;
    } state_t;

    state_t st_q, st_d;

    // ---------------- address decode ----------------
    logic [WIDX_W-1:0] widx;
    logic [WIDX_W-1:0] cfg_off;
    logic              aligned, cfg_hit;
    logic [LINE_W-1:0] cfg_sel;
    logic              hit_pend, hit_mask, hit_ctrl, hit_sw;
    logic [1:0]        hit_src;

    assign widx     = addr[ADDR_W-1:2];
    assign aligned  = (addr[1:0] == 2'b00);
    assign cfg_off  = widx - WIDX_W'(WI_CFG0);
    assign cfg_hit  = aligned && (widx >= WIDX_W'(WI_CFG0)) && (cfg_off < WIDX_W'(NLINES));
    assign cfg_sel  = cfg_off[LINE_W-1:0];
    assign hit_pend = aligned && (widx == WIDX_W'(WI_PEND));
    assign hit_mask = aligned && (widx == WIDX_W'(WI_MASK));
    assign hit_ctrl = aligned && (widx == WIDX_W'(WI_CTRL));
    assign hit_sw   = aligned && (widx == WIDX_W'(WI_SWSET));
    assign hit_src[PATH_NRM] = aligned && (widx == WIDX_W'(WI_SRC_NRM));
    assign hit_src[PATH_FST] = aligned && (widx == WIDX_W'(WI_SRC_FST));

    // ---------------- line events ----------------
    logic [NLINES-1:0] asrt_now, sw_req, set_vec, fall_vec;

    assign asrt_now = ~line_n;
    assign sw_req   = (wr_en && hit_sw) ? (wdata[NLINES-1:0] & (~wdata[NLINES-1:0] + 1'b1)) : '0;

    intc_line_events #(.NLINES(NLINES)) u_events (
        .asrt     (asrt_now),
        .in_prev  (st_q.in_prev),
        .sens     (st_q.sens),
        .sw_req   (sw_req),
        .set_vec  (set_vec),
        .fall_vec (fall_vec)
    );

    // ---------------- resolvers, one per output ----------------
    logic [1:0][NLINES-1:0] cand;
    logic [1:0][LINE_W-1:0] win;
    logic [1:0]             any;

    for (genvar k = 0; k < 2; k++) begin : g_path
        assign cand[k] = st_q.pend & ~st_q.mask & (k == 1 ? st_q.steer : ~st_q.steer);

        intc_arbiter #(.NLINES(NLINES), .PRIO_W(PRIO_W), .LINE_W(LINE_W)) u_arb (
            .cand (cand[k]),
            .prio (st_q.prio),
            .win  (win[k]),
            .any  (any[k])
        );
    end

    // ---------------- next state ----------------
    logic [NLINES-1:0] ack_clr;
    logic [NLINES-1:0] pend_n;

    always_comb begin
        st_d         = st_q;
        st_d.in_prev = asrt_now;

        // acknowledge by source read: edge lines only
        ack_clr = '0;
        for (int k = 0; k < 2; k++) begin
            if (rd_en && hit_src[k]) begin
                ack_clr[st_q.src[k]] = ~st_q.sens[st_q.src[k]];
            end
        end

        pend_n = st_q.pend;
        if (wr_en && hit_pend) begin
            pend_n = pend_n & (wdata[NLINES-1:0] | (st_q.sens & asrt_now));
        end
        pend_n    = ((pend_n & ~fall_vec) | set_vec) & ~ack_clr;
        st_d.pend = pend_n;

        if (wr_en && hit_mask) begin
            st_d.mask = wdata[NLINES-1:0];
        end
        if (wr_en && cfg_hit) begin
            st_d.prio[cfg_sel]  = wdata[CFG_W-1:2];
            st_d.sens[cfg_sel]  = wdata[1];
            st_d.steer[cfg_sel] = wdata[0];
        end

        // fire / re-arm; a re-arm in the same cycle overrides a fire
        for (int k = 0; k < 2; k++) begin
            if (st_q.agree[k] && any[k]) begin
                st_d.out[k]   = 1'b1;
                st_d.agree[k] = 1'b0;
                st_d.src[k]   = win[k];
            end
            if (wr_en && hit_ctrl && wdata[k]) begin
                st_d.out[k]   = 1'b0;
                st_d.agree[k] = 1'b1;
            end
        end

        if (rd_en) begin
            st_d.rdata = '0;
            if (hit_pend) begin
                st_d.rdata = DATA_W'(st_q.pend);
            end else if (hit_mask) begin
                st_d.rdata = DATA_W'(st_q.mask);
            end else if (hit_src[PATH_NRM]) begin
                st_d.rdata = DATA_W'(st_q.src[PATH_NRM]);
            end else if (hit_src[PATH_FST]) begin
                st_d.rdata = DATA_W'(st_q.src[PATH_FST]);
            end else if (cfg_hit) begin
                st_d.rdata = DATA_W'({st_q.prio[cfg_sel], st_q.sens[cfg_sel], st_q.steer[cfg_sel]});
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= '0;
            st_q.mask  <= '1;
            st_q.agree <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.rdata;
    assign irq_o = st_q.out[PATH_NRM];
    assign fiq_o = st_q.out[PATH_FST];

    // ---------------- assertions ----------------
    for (genvar k = 0; k < 2; k++) begin : g_chk
        AST_FIRE_NEEDS_AGREE: assert property (@(posedge clk) disable iff (rst)
            $rose(st_q.out[k]) |-> $past(st_q.agree[k])); // R6
        AST_FIRE_NEEDS_CAND: assert property (@(posedge clk) disable iff (rst)
            $rose(st_q.out[k]) |-> $past(any[k])); // R10
        AST_SRC_ONLY_ON_FIRE: assert property (@(posedge clk) disable iff (rst)
            !$stable(st_q.src[k]) |-> $rose(st_q.out[k])); // R6
        AST_CTRL_DROPS: assert property (@(posedge clk) disable iff (rst)
            (wr_en && hit_ctrl && wdata[k]) |=> !st_q.out[k]); // R9
    end

    AST_LEVEL_HELD: assert property (@(posedge clk) disable iff (rst)
        ((st_q.sens & asrt_now) != '0) |=> (($past(st_q.sens & asrt_now) & ~st_q.pend) == '0)); // R4
endmodule

// File: tb/intc_bank_bench.sv
`timescale 1ns/100ps
module intc_bank_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] line_n = '1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_o, fiq_o;

    int total = 0;
    int bad   = 0;
    int prio_m[32];

    always #2.5 clk = ~clk;

    intc_bank u_intc_bank (
        .clk(clk), .rst(rst), .line_n(line_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .fiq_o(fiq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; line_n = '1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic int winner(input logic [31:0] p);
        int best = 99;
        int w = 0;
        for (int i = 0; i < 32; i++) begin
            if (p[i] && prio_m[i] <= best) begin
                best = prio_m[i];
                w = i;
            end
        end
        return w;
    endfunction

    // Drain a pending set through the normal output, checking winner order
    task automatic drain(input logic [31:0] pat, input int mul, input int add, input int modv);
        logic [31:0] v;
        logic [31:0] pm;
        do_reset();
        for (int n = 0; n < 32; n++) begin
            prio_m[n] = (n * mul + add) % modv;
            wr(8'(28 + 4 * n), 32'(prio_m[n]) << 2);
        end
        for (int i = 0; i < 32; i++) begin
            if (pat[i]) wr(8'h9C, 32'h1 << i);
        end
        rd(8'h00, v); chk("R11 pending after single-bit raises", v, pat);
        chk("R10 masked pending keeps irq low", {31'b0, irq_o}, 32'd0);
        wr(8'h04, 32'h0);
        @(negedge clk);
        chk("R10 unmask fires irq", {31'b0, irq_o}, 32'd1);
        pm = pat;
        while (pm != 0) begin
            int w = winner(pm);
            rd(8'h10, v); chk("R7 winner order", v, 32'(w));
            pm[w] = 1'b0;
            wr(8'h18, 32'h1);
            chk("R9 ctrl lowers irq", {31'b0, irq_o}, 32'd0);
            @(negedge clk);
            chk("R9 re-fire while candidates remain", {31'b0, irq_o}, {31'b0, pm != 0});
        end
        rd(8'h00, v); chk("R8 edge acks cleared all pending", v, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        do_reset();

        // R1 reset state
        rd(8'h04, v); chk("R1 mask reset", v, 32'hFFFF_FFFF);
        rd(8'h00, v); chk("R1 pending reset", v, 32'd0);
        rd(8'h1C + 8'd12, v); chk("R1 line reg reset", v, 32'd0);
        rd(8'h10, v); chk("R1 normal source reset", v, 32'd0);
        rd(8'h14, v); chk("R1 fast source reset", v, 32'd0);
        chk("R1 outputs low", {30'b0, irq_o, fiq_o}, 32'd0);

        // R2 line register sweep
        for (int n = 0; n < 32; n++) wr(8'(28 + 4 * n), 32'hFFFF_FF80 | 32'(((n * 13) % 32) << 2) | 32'(n % 4));
        for (int n = 0; n < 32; n++) begin
            rd(8'(28 + 4 * n), v);
            chk("R2 line reg readback", v, 32'(((n * 13) % 32) << 2) | 32'(n % 4));
        end

        // R3 edge, R4 level, R5 pending write
        do_reset();
        wr(8'h1C + 8'd20, 32'h0);   // line 5 edge
        wr(8'h1C + 8'd24, 32'h2);   // line 6 level
        @(negedge clk); line_n[5] = 1'b0;
        @(negedge clk);
        rd(8'h00, v); chk("R3 edge sets pending", v, 32'h20);
        wr(8'h00, ~32'h20);
        rd(8'h00, v); chk("R3 held-low edge not re-set", v, 32'h0);
        line_n[5] = 1'b1; @(negedge clk); line_n[5] = 1'b0; @(negedge clk);
        rd(8'h00, v); chk("R3 second fall sets again", v, 32'h20);
        line_n[5] = 1'b1;
        wr(8'h00, 32'h0);
        wr(8'h9C, 32'h2); wr(8'h9C, 32'h4); wr(8'h9C, 32'h8);
        wr(8'h00, 32'h0000_000A);
        rd(8'h00, v); chk("R5 pending AND", v, 32'h0000_000A);
        wr(8'h00, 32'h0);
        line_n[6] = 1'b0; @(negedge clk);
        rd(8'h00, v); chk("R4 level sets pending", v, 32'h40);
        wr(8'h00, 32'h0);
        rd(8'h00, v); chk("R4 clear ignored while low", v, 32'h40);
        line_n[6] = 1'b1; @(negedge clk);
        rd(8'h00, v); chk("R4 release clears pending", v, 32'h0);

        // R11 lowest bit only
        wr(8'h9C, 32'h0000_0110);
        rd(8'h00, v); chk("R11 lowest bit raised", v, 32'h10);
        wr(8'h00, 32'h0);
        line_n[5] = 1'b0; @(negedge clk);
        wr(8'h00, 32'h0);
        wr(8'h9C, 32'h20);
        rd(8'h00, v); chk("R11 edge line already low not raised", v, 32'h0);
        line_n[5] = 1'b1;

        // R8 level line stays pending after source read
        do_reset();
        wr(8'h1C + 8'd24, 32'h2);
        line_n[6] = 1'b0;
        wr(8'h04, ~32'h40);
        @(negedge clk);
        chk("R6 level line fires irq", {31'b0, irq_o}, 32'd1);
        rd(8'h10, v); chk("R8 source returns level line", v, 32'd6);
        rd(8'h00, v); chk("R8 level stays pending after read", v, 32'h40);
        line_n[6] = 1'b1;

        // R6/R9 fast path and agreement gate
        do_reset();
        wr(8'h1C + 8'd36, (32'd4 << 2) | 32'h1);   // line 9 fast, prio 4
        wr(8'h1C + 8'd40, 32'h1);                  // line 10 fast, prio 0
        wr(8'h9C, 32'h200);
        wr(8'h04, ~32'h600);
        @(negedge clk);
        chk("R6 fast output fires", {30'b0, irq_o, fiq_o}, 32'd1);
        wr(8'h9C, 32'h400);
        @(negedge clk);
        rd(8'h14, v); chk("R6 no re-latch without agreement", v, 32'd9);
        wr(8'h10, 32'h1F);
        rd(8'h14, v); chk("R12 source write ignored", v, 32'd9);
        wr(8'h18, 32'h2);
        chk("R9 ctrl bit1 lowers fiq", {31'b0, fiq_o}, 32'd0);
        @(negedge clk);
        chk("R9 fiq re-fires", {31'b0, fiq_o}, 32'd1);
        rd(8'h14, v); chk("R7 new fast winner", v, 32'd10);

        // R12 zero reads and ignored writes
        rd(8'h18, v); chk("R12 ctrl reads 0", v, 32'd0);
        rd(8'h9C, v); chk("R12 swset reads 0", v, 32'd0);
        rd(8'h04, v);
        wr(8'hA0, 32'hFFFF_FFFF);
        wr(8'h06, 32'hFFFF_FFFF);
        rd(8'h04, v); chk("R12 unmapped write leaves mask", v, ~32'h600);
        rd(8'hFC, v); chk("R12 unmapped reads 0", v, 32'd0);
        rd(8'h05, v); chk("R12 unaligned reads 0", v, 32'd0);

        // R7 drains with ties
        drain(32'hFFFF_FFFF, 5, 3, 8);
        drain(32'hA5C3_0F19, 11, 7, 32);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule